// File: doc/BRIEF.md
# Multi-bank SDRAM sequencer with concurrent auto precharge

This block is a cycle-level, synthesizable model of the bank bookkeeping and data-bus timing inside a multi-bank SDRAM. One command is sampled on every rising clock edge, each with a bank and a column. The block keeps a state per bank (idle, open, write recovery, precharging). It runs a single burst generator that steps the column through an aligned group of four. It pushes read beats through a CAS-latency pipeline and stores write beats in a small internal array. Read data leaves on `dq_out`, qualified by the tri-state enable `dq_oe`. A byte-mask input suppresses read output two clocks later and suppresses write storage at once.

The feature being modelled is concurrent auto precharge. While a burst that closes its own bank is still issuing beats, a READ or WRITE to a different open bank is legal. That access cuts the running burst short, and the interrupted bank begins closing at the very edge the interrupting command is registered. A READ that interrupts lets the older read beats already in flight drain, so the change of owner on the bus happens one CAS latency later. A WRITE that interrupts cancels every read beat not yet on the bus. The single beat leaving at that edge can only be kept off the bus by raising the mask two clocks earlier.

Top module: `cap_bank_seq`

## Requirements
- R1: Command codes on `cmd` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, READ with auto precharge=4, WRITE with auto precharge=5; codes 6 and 7 behave as NOP. ACTIVATE to an idle bank sets its `bank_open` bit after that edge. ACTIVATE to a bank that is not idle raises `cmd_err` for one period and changes nothing.
- R2: A READ registered at edge E puts its first beat on `dq_out`, with `dq_oe` high, in the period after edge E+CL (CL=3). The remaining beats follow in the next three periods (burst of 4). `dq_oe` is low in the period before the first beat and in the period after the last one.
- R3: A burst starting at column c visits c first. It then increments only the two low column bits, modulo 4, with the upper column bits held: start 6 gives 6, 7, 4, 5.
- R4: A WRITE registered at edge E stores `dq_in` sampled at edges E to E+3 into the wrapped columns of that burst. A beat whose edge sees `dqm` high is not stored, and the old word remains.
- R5: `dqm` high at edge X forces `dq_oe` low in the period after edge X+2, while other read beats are still driven.
- R6: A READ to another open bank registered during a read burst ends the older burst. With the new READ two edges after the old one, the bus shows old beats 0 and 1 and then the new burst's four beats without a gap.
- R7: A WRITE registered at edge W cancels every read beat not yet driven. The beat loaded at edge W is still driven in the following period unless `dqm` was high at edge W-2, and `dq_oe` stays low from the period after edge W+1.
- R8: A READ with auto precharge that is not interrupted closes its bank at the edge its fourth beat is issued (E+3): `bank_open` drops and `bank_busy` rises. The bank is idle (both low) T_RP edges later (default 2).
- R9: A WRITE with auto precharge that is not interrupted enters write recovery at the edge of its fourth beat. The bank stays busy for T_WR + T_RP edges (defaults 2 and 2) and is then idle.
- R10: An access to a different open bank registered at edge I, while an auto-precharge burst is issuing beats, makes the interrupted bank busy from edge I. An interrupted read then becomes idle at I+T_RP, and an interrupted write at I+T_WR+T_RP.
- R11: A READ or WRITE of either kind to a bank that is not open, or to the bank whose auto-precharge burst is still issuing, raises `cmd_err` for the next period. It is otherwise ignored: no beat is driven or stored, and the running burst continues.
- R12: After reset all banks are idle, and `dq_oe` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (see R1) |
| bank | input | 2 | Bank addressed by the command |
| col | input | 3 | Starting column of an access |
| dqm | input | 1 | Data mask: write mask at once, read output mask two clocks later |
| dq_in | input | 16 | Write data, sampled on each write beat edge |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Output enable of the data pins (high = driving) |
| cmd_err | output | 1 | One-period flag for a rejected command |
| bank_open | output | 4 | One bit per bank: row open and accessible |
| bank_busy | output | 4 | One bit per bank: write recovery or precharge in progress |

## Verification
A wrong bank state shows on `bank_open` and `bank_busy` in the very period after the faulty edge. A closing bank that still accepts accesses shows as a missing `cmd_err` one period later. Errors in the burst counter or the read pipeline show only CL periods after the command, as a wrong word, a beat on the wrong period or a hole in `dq_oe`. The bench therefore logs every port on every period and compares exact periods around each interrupt. A mask or flush error is visible only in the one or two periods around a read-to-write turnaround, so those periods are checked one by one.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int COL_W  = 3;
    localparam int BL_W   = 2;
    localparam int BL     = 1 << BL_W;

    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_ACT = 3'd1,
        C_RD  = 3'd2,
        C_WR  = 3'd3,
        C_RDA = 3'd4,
        C_WRA = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_OPEN = 2'd1,
        B_PRE  = 2'd2,
        B_WREC = 2'd3
    } bank_st_e;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              ap;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } beat_t;

    function automatic logic is_access(input cmd_e c);
        return (c == C_RD) || (c == C_WR) || (c == C_RDA) || (c == C_WRA);
    endfunction

    function automatic logic is_write(input cmd_e c);
        return (c == C_WR) || (c == C_WRA);
    endfunction

    function automatic logic is_autopre(input cmd_e c);
        return (c == C_RDA) || (c == C_WRA);
    endfunction

    // column of beat idx inside the aligned group that holds base
    function automatic logic [COL_W-1:0] wrap_col(input logic [COL_W-1:0] base,
                                                  input logic [BL_W-1:0]  idx);
        return {base[COL_W-1:BL_W], base[BL_W-1:0] + idx};
    endfunction
endpackage

// File: rtl/cap_bank_fsm.sv
`timescale 1ns/1ps
module cap_bank_fsm
    import cap_pkg::*;
#(
    parameter int T_RP = 2,
    parameter int T_WR = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     open_req,
    input  logic     close_req,
    input  logic     close_wr,
    output bank_st_e st
);
    localparam int TMAX = (T_RP > T_WR) ? T_RP : T_WR;
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= B_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                B_IDLE: if (open_req) st <= B_OPEN;
                B_OPEN: begin
                    if (close_req) begin
                        if (close_wr) begin
                            st  <= B_WREC;
                            cnt <= CW'(T_WR - 1);
                        end else begin
                            st  <= B_PRE;
                            cnt <= CW'(T_RP - 1);
                        end
                    end
                end
                B_WREC: begin
                    if (cnt == '0) begin
                        st  <= B_PRE;
                        cnt <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                B_PRE: begin
                    if (cnt == '0) st <= B_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= B_IDLE;
            endcase
        end
    end

    // checker: length of every precharge phase
    logic [CW:0] pre_len;
    always_ff @(posedge clk) begin
        if (rst)               pre_len <= '0;
        else if (st == B_PRE)  pre_len <= pre_len + 1'b1;
        else                   pre_len <= '0;
    end

    AST_PRE_LEN: assert property (@(posedge clk) disable iff (rst)
        (st == B_PRE) |=> (st == B_PRE || pre_len == (CW+1)'(T_RP))); // R8
    AST_WREC_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st == B_WREC) |=> (st == B_WREC || st == B_PRE)); // R9
    AST_OPEN_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == B_PRE || st == B_WREC) |=> (st != B_OPEN)); // R1
endmodule

// File: rtl/cap_burst_gen.sv
`timescale 1ns/1ps
module cap_burst_gen
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_ok,
    input  cmd_e              c,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    output beat_t             issue,
    output logic              close_req,
    output logic [BANK_W-1:0] close_bank,
    output logic              close_wr,
    output logic              ap_busy,
    output logic [BANK_W-1:0] ap_bank
);
    beat_t           cur;
    logic [BL_W-1:0] left;
    logic            run;

    assign run = (left != '0);

    always_comb begin
        issue = '0;
        if (acc_ok) begin
            issue.vld  = 1'b1;
            issue.wr   = is_write(c);
            issue.ap   = is_autopre(c);
            issue.bank = bank_i;
            issue.col  = col_i;
        end else if (run) begin
            issue.vld  = 1'b1;
            issue.wr   = cur.wr;
            issue.ap   = cur.ap;
            issue.bank = cur.bank;
            issue.col  = wrap_col(cur.col, BL_W'(BL) - left);
        end
    end

    // an auto-precharge burst closes at its last beat or when cut short
    assign close_req  = cur.ap && run && (acc_ok || left == BL_W'(1));
    assign close_bank = cur.bank;
    assign close_wr   = cur.wr;
    assign ap_busy    = run && cur.ap;
    assign ap_bank    = cur.bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            left <= '0;
        end else if (acc_ok) begin
            cur  <= issue;
            left <= BL_W'(BL - 1);
        end else if (run) begin
            left <= left - 1'b1;
        end
    end

    AST_CUT_OTHER_BANK: assert property (@(posedge clk) disable iff (rst)
        (acc_ok && run && cur.ap) |-> (bank_i != cur.bank)); // R11
endmodule

// File: rtl/cap_read_pipe.sv
`timescale 1ns/1ps
module cap_read_pipe
    import cap_pkg::*;
#(
    parameter int CL = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t issue,
    input  logic  dqm,
    output beat_t head,
    output logic  oe
);
    beat_t      p [CL];
    logic [1:0] dqm_sr;
    logic       flush;

    assign flush = issue.vld && issue.wr;
    assign head  = p[CL-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CL; i++) p[i] <= '0;
            dqm_sr <= '0;
            oe     <= 1'b0;
        end else begin
            dqm_sr <= {dqm_sr[0], dqm};
            oe     <= p[CL-1].vld && !dqm_sr[1];
            if (flush) begin
                for (int i = 0; i < CL; i++) p[i] <= '0;
            end else begin
                p[0] <= issue.vld ? issue : '0;
                for (int i = 1; i < CL; i++) p[i] <= p[i-1];
            end
        end
    end

    AST_OE_MASK: assert property (@(posedge clk) disable iff (rst)
        oe |-> !$past(dqm, 3)); // R5
endmodule

// File: rtl/cap_bank_seq.sv
`timescale 1ns/1ps
module cap_bank_seq
    import cap_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CL   = 3,
    parameter int T_RP = 2,
    parameter int T_WR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              dqm,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic              cmd_err,
    output logic [NBANK-1:0]  bank_open,
    output logic [NBANK-1:0]  bank_busy
);
    localparam int DEPTH = NBANK << COL_W;

    cmd_e              c;
    bank_st_e          st_q [NBANK];
    logic              acc, acc_ok, act_ok, err_d;
    beat_t             beat, head;
    logic              close_req, close_wr, ap_busy;
    logic [BANK_W-1:0] close_bank, ap_bank;
    logic [DW-1:0]     mem [DEPTH];

    assign c      = cmd_e'(cmd);
    assign acc    = is_access(c);
    assign acc_ok = acc && (st_q[bank] == B_OPEN) && !(ap_busy && ap_bank == bank);
    assign act_ok = (c == C_ACT) && (st_q[bank] == B_IDLE);
    assign err_d  = (acc && !acc_ok) || ((c == C_ACT) && !act_ok);

    cap_burst_gen u_burst (
        .clk        (clk),
        .rst        (rst),
        .acc_ok     (acc_ok),
        .c          (c),
        .bank_i     (bank),
        .col_i      (col),
        .issue      (beat),
        .close_req  (close_req),
        .close_bank (close_bank),
        .close_wr   (close_wr),
        .ap_busy    (ap_busy),
        .ap_bank    (ap_bank)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        cap_bank_fsm #(.T_RP(T_RP), .T_WR(T_WR)) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .open_req  (act_ok && bank == BANK_W'(g)),
            .close_req (close_req && close_bank == BANK_W'(g)),
            .close_wr  (close_wr),
            .st        (st_q[g])
        );
        assign bank_open[g] = (st_q[g] == B_OPEN);
        assign bank_busy[g] = (st_q[g] == B_PRE) || (st_q[g] == B_WREC);
    end

    cap_read_pipe #(.CL(CL)) u_rpipe (
        .clk   (clk),
        .rst   (rst),
        .issue (beat),
        .dqm   (dqm),
        .head  (head),
        .oe    (dq_oe)
    );

    always_ff @(posedge clk) begin
        if (beat.vld && beat.wr && !dqm) mem[{beat.bank, beat.col}] <= dq_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out  <= '0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= err_d;
            if (head.vld) dq_out <= mem[{head.bank, head.col}];
        end
    end

    AST_ERR_ON_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (acc && st_q[bank] != B_OPEN) |=> cmd_err); // R11
    AST_WRITE_SILENCES_BUS: assert property (@(posedge clk) disable iff (rst)
        (beat.vld && beat.wr) |=> ##1 !dq_oe); // R7
endmodule

// File: tb/cap_bank_seq_bench.sv
`timescale 1ns/1ps
module cap_bank_seq_bench;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, RDA = 3'd4, WRA = 3'd5;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [2:0]  col;
    logic        dqm;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic        dq_oe, cmd_err;
    logic [3:0]  bank_open, bank_busy;

    always #5 clk = ~clk;

    cap_bank_seq u_cap_bank_seq (
        .clk(clk), .rst(rst), .cmd(cmd), .bank(bank), .col(col), .dqm(dqm),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cmd_err(cmd_err),
        .bank_open(bank_open), .bank_busy(bank_busy)
    );

    int total = 0, fails = 0, n = 0;
    bit done = 0;
    logic [15:0] o_dq   [0:1023];
    logic        o_oe   [0:1023];
    logic        o_err  [0:1023];
    logic [3:0]  o_open [0:1023];
    logic [3:0]  o_busy [0:1023];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, observe after the following rising edge
    task automatic step(logic [2:0] c, int b, int cl, logic m, logic [15:0] d);
        cmd = c; bank = b[1:0]; col = cl[2:0]; dqm = m; dq_in = d;
        @(negedge clk);
        o_dq[n] = dq_out; o_oe[n] = dq_oe; o_err[n] = cmd_err;
        o_open[n] = bank_open; o_busy[n] = bank_busy;
        n++;
    endtask

    task automatic nop(int k);
        for (int i = 0; i < k; i++) step(NOP, 0, 0, 1'b0, 16'h0);
    endtask

    task automatic wburst(logic [2:0] c, int b, int cl, logic [15:0] d0, logic [15:0] d1,
                          logic [15:0] d2, logic [15:0] d3, logic [3:0] msk);
        step(c, b, cl, msk[0], d0);
        step(NOP, 0, 0, msk[1], d1);
        step(NOP, 0, 0, msk[2], d2);
        step(NOP, 0, 0, msk[3], d3);
    endtask

    task automatic beat(string req, int idx, logic [15:0] exp);
        chk(req, $sformatf("oe at obs %0d", idx), o_oe[idx], 1);
        chk(req, $sformatf("data at obs %0d", idx), o_dq[idx], exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; cmd = NOP; bank = 0; col = 0; dqm = 0; dq_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12", "bank_open", bank_open, 0);
        chk("R12", "bank_busy", bank_busy, 0);
        chk("R12", "dq_oe", dq_oe, 0);
        chk("R12", "cmd_err", cmd_err, 0);
    endtask

    task automatic t_open();
        int s;
        for (int b = 0; b < 4; b++) step(ACT, b, 0, 1'b0, 16'h0);
        s = n - 1;
        chk("R1", "all banks open", o_open[s], 4'hF);
        chk("R1", "no error on legal activate", o_err[s], 0);
        step(ACT, 0, 0, 1'b0, 16'h0);
        chk("R1", "activate of open bank flagged", o_err[n-1], 1);
        chk("R1", "banks unchanged", o_open[n-1], 4'hF);
        step(6, 2, 0, 1'b0, 16'h0);
        chk("R1", "unused code acts as nop", o_err[n-1], 0);
    endtask

    task automatic t_write_read();
        int s;
        wburst(WR, 1, 5, 16'hA0, 16'hA1, 16'hA2, 16'hA3, 4'b0000);
        wburst(WR, 1, 0, 16'hC0, 16'hC1, 16'hC2, 16'hC3, 4'b0000);
        wburst(WR, 1, 0, 16'hB0, 16'hB1, 16'hB2, 16'hB3, 4'b0100);
        nop(2);
        s = n; step(RD, 1, 6, 1'b0, 16'h0); nop(8);
        chk("R2", "bus idle before first beat", o_oe[s+2], 0);
        beat("R3", s+3, 16'hA1);
        beat("R3", s+4, 16'hA2);
        beat("R3", s+5, 16'hA3);
        beat("R2", s+6, 16'hA0);
        chk("R2", "bus idle after last beat", o_oe[s+7], 0);
        s = n; step(RD, 1, 0, 1'b0, 16'h0); nop(7);
        beat("R4", s+3, 16'hB0);
        beat("R4", s+4, 16'hB1);
        beat("R4", s+5, 16'hC2);
        beat("R4", s+6, 16'hB3);
    endtask

    task automatic t_dqm_read();
        int s;
        s = n;
        step(RD, 1, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b1, 16'h0);
        nop(7);
        beat("R5", s+3, 16'hB0);
        chk("R5", "masked beat not driven", o_oe[s+4], 0);
        beat("R5", s+5, 16'hC2);
        beat("R5", s+6, 16'hB3);
    endtask

    task automatic t_read_interrupt();
        int s;
        wburst(WR, 2, 0, 16'h200, 16'h201, 16'h202, 16'h203, 4'b0000);
        wburst(WR, 3, 4, 16'h304, 16'h305, 16'h306, 16'h307, 4'b0000);
        nop(1);
        s = n;
        step(RDA, 2, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b0, 16'h0);
        step(RD, 3, 4, 1'b0, 16'h0);
        nop(8);
        beat("R6", s+3, 16'h200);
        beat("R6", s+4, 16'h201);
        beat("R6", s+5, 16'h304);
        beat("R6", s+6, 16'h305);
        beat("R6", s+7, 16'h306);
        beat("R6", s+8, 16'h307);
        chk("R6", "bus idle after new burst", o_oe[s+9], 0);
        chk("R10", "bank 2 open before cut", o_open[s+1][2], 1);
        chk("R10", "bank 2 busy at cut edge", o_busy[s+2][2], 1);
        chk("R10", "bank 2 closed at cut edge", o_open[s+2][2], 0);
        chk("R10", "bank 2 still precharging", o_busy[s+3][2], 1);
        chk("R10", "bank 2 idle after tRP", o_busy[s+4][2], 0);
        chk("R10", "bank 3 stays open", o_open[s+4][3], 1);
    endtask

    task automatic t_closing();
        int s;
        s = n;
        step(RDA, 3, 4, 1'b0, 16'h0);
        step(RD, 3, 4, 1'b0, 16'h0);
        nop(8);
        chk("R11", "access to closing bank flagged", o_err[s+1], 1);
        beat("R11", s+3, 16'h304);
        beat("R11", s+4, 16'h305);
        beat("R11", s+5, 16'h306);
        beat("R11", s+6, 16'h307);
        chk("R11", "no extra beat", o_oe[s+7], 0);
        chk("R8", "open until last beat", o_open[s+2][3], 1);
        chk("R8", "busy at last beat edge", o_busy[s+3][3], 1);
        chk("R8", "busy during tRP", o_busy[s+4][3], 1);
        chk("R8", "idle after tRP busy", o_busy[s+5][3], 0);
        chk("R8", "idle after tRP open", o_open[s+5][3], 0);
        s = n;
        step(RD, 3, 0, 1'b0, 16'h0);
        nop(7);
        chk("R11", "read of idle bank flagged", o_err[s], 1);
        chk("R11", "flag lasts one period", o_err[s+1], 0);
        for (int k = 0; k < 8; k++) chk("R11", "no drive for rejected read", o_oe[s+k], 0);
    endtask

    task automatic t_write_ap();
        int s;
        s = n;
        wburst(WRA, 0, 0, 16'hD0, 16'hD1, 16'hD2, 16'hD3, 4'b0000);
        nop(5);
        chk("R9", "open before last beat", o_open[s+2][0], 1);
        chk("R9", "busy at last beat edge", o_busy[s+3][0], 1);
        chk("R9", "busy through recovery", o_busy[s+6][0], 1);
        chk("R9", "idle after tWR+tRP", o_busy[s+7][0], 0);
        chk("R9", "not open when idle", o_open[s+7][0], 0);
        step(ACT, 0, 0, 1'b0, 16'h0);
        s = n; step(RD, 0, 1, 1'b0, 16'h0); nop(7);
        beat("R4", s+3, 16'hD1);
        beat("R4", s+4, 16'hD2);
        beat("R4", s+5, 16'hD3);
        beat("R4", s+6, 16'hD0);
    endtask

    task automatic t_turnaround();
        int s;
        // write four edges after a read, no mask: beat 1 still leaves (contention)
        s = n;
        step(RD, 1, 0, 1'b0, 16'h0); nop(3);
        wburst(WR, 0, 4, 16'h55, 16'h56, 16'h57, 16'h58, 4'b0000);
        nop(3);
        beat("R7", s+3, 16'hB0);
        beat("R7", s+4, 16'hB1);
        chk("R7", "cancelled beat 2", o_oe[s+5], 0);
        chk("R7", "cancelled beat 3", o_oe[s+6], 0);
        chk("R7", "bus stays released", o_oe[s+7], 0);
        // same with mask two clocks before the write
        s = n;
        step(RD, 1, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b1, 16'h0);
        step(NOP, 0, 0, 1'b0, 16'h0);
        wburst(WR, 0, 4, 16'h65, 16'h66, 16'h67, 16'h68, 4'b0000);
        nop(3);
        beat("R7", s+3, 16'hB0);
        chk("R7", "masked turnaround beat", o_oe[s+4], 0);
        chk("R7", "no beat after write", o_oe[s+5], 0);
        // write with auto precharge cutting a read with auto precharge
        s = n;
        step(RDA, 1, 0, 1'b0, 16'h0);
        step(NOP, 0, 0, 1'b0, 16'h0);
        wburst(WRA, 0, 0, 16'h70, 16'h71, 16'h72, 16'h73, 4'b0000);
        nop(7);
        chk("R10", "bank 1 open before cut", o_open[s+1][1], 1);
        chk("R10", "bank 1 busy at write edge", o_busy[s+2][1], 1);
        chk("R10", "bank 1 busy during tRP", o_busy[s+3][1], 1);
        chk("R10", "bank 1 idle after tRP", o_busy[s+4][1], 0);
        for (int k = 3; k < 7; k++) chk("R7", "read beats cancelled", o_oe[s+k], 0);
        chk("R9", "bank 0 open during burst", o_open[s+4][0], 1);
        chk("R9", "bank 0 busy at last beat", o_busy[s+5][0], 1);
        chk("R9", "bank 0 busy before idle", o_busy[s+8][0], 1);
        chk("R9", "bank 0 idle", o_busy[s+9][0], 0);
    endtask

    initial begin
        t_reset();
        t_open();
        t_write_read();
        t_dqm_read();
        t_read_interrupt();
        t_closing();
        t_write_ap();
        t_turnaround();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule